// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block gathers eight level-sensitive interrupt request lines from peripheral devices and forwards a single request to a processor. Every source has a software-programmed vector byte and its own enable bit. A source that is not enabled plays no part in the outgoing request or in the choice of vector. When the processor answers with its acknowledge signal, the arbiter chooses the enabled pending source with the highest fixed priority. Line 0 wins over line 7. The arbiter captures that source's vector and holds it on the vector output until the acknowledge is released.

Software programs the arbiter through a plain write strobe with an address and a data byte. Addresses 0 to 7 hold the per-source vectors and address 8 holds the enable mask. Requests are levels, so a device keeps asking until its driver clears the request at the device. If the acknowledge arrives when no enabled line is pending, the arbiter returns a reserved spurious vector.

Top module: `irqArb`

## Requirements
- R1: After reset `irqOut` and `vecValid` are 0, every vector register holds 0 and the enable mask is 0, so no source is enabled.
- R2: `irqOut` is 1 in the same cycle in which at least one input has `irqIn[i]=1` and enable bit i set, and it is 0 otherwise.
- R3: A source whose enable bit is 0 changes neither `irqOut` nor the captured vector.
- R4: Priority is fixed. Among the enabled pending inputs, the lowest index wins.
- R5: `vecValid` becomes 1 at the first clock edge at which `intAck` is sampled high. It returns to 0 at the first edge at which `intAck` is sampled low.
- R6: The vector is captured only at the edge at which an acknowledge starts. While `intAck` stays high, `vecOut` stays constant even if the inputs, the mask or the vector registers change.
- R7: If an acknowledge starts with no enabled source pending, the captured vector is 0xFF.
- R8: A write with `wrEn=1` to address i in 0..7 loads vector i from `wrData`. Address 8 loads the enable mask, where bit i enables source i. Writes to addresses 9..15 change nothing.
- R9: Requests are levels. When a device drops its line, `irqOut` falls in the same cycle if no other enabled source is pending, and the next acknowledge selects among the remaining sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Level request lines, index 0 highest priority |
| intAck | input | 1 | Processor interrupt acknowledge |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address: 0..7 vectors, 8 mask |
| wrData | input | 8 | Register write data |
| irqOut | output | 1 | Request to the processor |
| vecOut | output | 8 | Captured vector |
| vecValid | output | 1 | Vector valid during acknowledge |

## Verification
The bench builds the arbiter with its defaults: eight sources, 8-bit vectors and a spurious code of 0xFF. With these values every enable bit, every address that is decoded or ignored, and the spurious code can be driven directly. The address map places the mask at 8, so the unused addresses 9 to 15 are real stimulus and can be checked as ignored. Eight sources keep the priority cases small enough to cover the top and bottom of the chain, gaps in the pattern, and masked winners that hand the grant to a lower-priority line.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  typedef struct packed {
    logic latchVec;   // capture the selected vector this edge
    logic ackActive;  // acknowledge is being held
  } arbStrobes_t;
endpackage

// File: rtl/irqArbCtrl.sv
module irqArbCtrl
  import irqArbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        intAck,
  output arbStrobes_t strobes
);
  typedef enum logic {ACK_IDLE, ACK_HOLD} ackState_t;
  ackState_t ackState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackState <= ACK_IDLE;
    else       ackState <= intAck ? ACK_HOLD : ACK_IDLE;
  end

  always_comb begin
    strobes.latchVec  = intAck && (ackState == ACK_IDLE);
    strobes.ackActive = (ackState == ACK_HOLD);
  end

  // R5: valid tracks acknowledge one edge later
  p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> strobes.ackActive);
  p_valid_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    !intAck |=> !strobes.ackActive);
endmodule

// File: rtl/irqArbDatapath.sv
module irqArbDatapath
  import irqArbPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter logic [VEC_W-1:0] SPURIOUS_VEC = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  arbStrobes_t        strobes,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vecOut
);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_SRC);

  logic [VEC_W-1:0]   vecMem [NUM_SRC];
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC:0]   higherPend;
  logic [NUM_SRC-1:0] grant;
  logic [VEC_W-1:0]   selVec;
  logic [VEC_W-1:0]   vecReg;

  // register programming
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskReg <= '0;
    else if (wrEn && wrAddr == MASK_ADDR) maskReg <= wrData[NUM_SRC-1:0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_vec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) vecMem[i] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(i)) vecMem[i] <= wrData[VEC_W-1:0];
    end
  end

  // fixed priority chain, index 0 highest
  assign pend = irqIn & maskReg;
  assign higherPend[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    assign grant[i]        = pend[i] & ~higherPend[i];
    assign higherPend[i+1] = higherPend[i] | pend[i];
  end

  always_comb begin
    selVec = higherPend[NUM_SRC] ? '0 : SPURIOUS_VEC;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant[i]) selVec = selVec | vecMem[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vecReg <= '0;
    else if (strobes.latchVec) vecReg <= selVec;
  end

  assign irqOut = |pend;
  assign vecOut = vecReg;

  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  p_quiet_inputs_r2: assert property (@(posedge clk) disable iff (!rstN)
    (irqIn == '0) |-> !irqOut);
  p_spurious_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchVec && pend == '0) |=> (vecOut == SPURIOUS_VEC));
endmodule

// File: rtl/irqArb.sv
module irqArb #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8,
  parameter logic [VEC_W-1:0] SPURIOUS_VEC = '1,
  localparam int DATA_W = (VEC_W > NUM_SRC) ? VEC_W : NUM_SRC,
  localparam int ADDR_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               intAck,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vecOut,
  output logic               vecValid
);
  irqArbPkg::arbStrobes_t strobes;

  irqArbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .intAck(intAck), .strobes(strobes)
  );

  irqArbDatapath #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .SPURIOUS_VEC(SPURIOUS_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strobes(strobes), .irqOut(irqOut), .vecOut(vecOut)
  );

  assign vecValid = strobes.ackActive;

  // R6: captured vector constant while acknowledge is held
  p_vec_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && $past(vecValid)) |-> $stable(vecOut));
endmodule

// File: tb/irqArb_test.sv
module irqArb_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       intAck = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       irqOut;
  logic [7:0] vecOut;
  logic       vecValid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irqArb uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // start acknowledge, check captured vector, release
  task automatic ackExpect(input string req, input logic [7:0] exp);
    intAck = 1'b1;
    @(negedge clk);
    chk({req, " valid"}, vecValid, 1);
    chk({req, " vector"}, vecOut, exp);
    intAck = 1'b0;
    @(negedge clk);
    chk({req, " valid drop"}, vecValid, 0);
  endtask

  task automatic t_reset_r1();
    irqIn = 8'hFF;
    @(negedge clk); #1;
    chk("R1 irqOut after reset", irqOut, 0);
    chk("R1 vecValid after reset", vecValid, 0);
    ackExpect("R1 mask clear gives spurious", 8'hFF);
    wr(4'd8, 8'h08);
    irqIn = 8'h08;
    ackExpect("R1 vector cleared", 8'h00);
  endtask

  task automatic t_program_r8();
    for (int i = 0; i < 8; i++) wr(4'(i), 8'h40 + 8'(i));
    wr(4'd8, 8'hFF);
    irqIn = 8'h20;
    ackExpect("R8 vector 5 loaded", 8'h45);
    for (int a = 9; a < 16; a++) wr(4'(a), 8'h00);
    #1 chk("R8 ignored address keeps mask", irqOut, 1);
    ackExpect("R8 ignored address keeps vector", 8'h45);
  endtask

  task automatic t_request_r2_r3();
    irqIn = 8'h10; #1;
    chk("R2 enabled pending raises irqOut", irqOut, 1);
    wr(4'd8, 8'hEF);
    #1 chk("R3 masked source ignored by irqOut", irqOut, 0);
    irqIn = 8'h30; #1;
    chk("R2 other enabled source", irqOut, 1);
    ackExpect("R3 masked source not selected", 8'h45);
    wr(4'd8, 8'hFF);
  endtask

  task automatic t_priority_r4();
    irqIn = 8'hA4; ackExpect("R4 lowest index of A4", 8'h42);
    irqIn = 8'h80; ackExpect("R4 only line 7", 8'h47);
    irqIn = 8'h81; ackExpect("R4 line 0 beats line 7", 8'h40);
    irqIn = 8'hFF; wr(4'd8, 8'hFC);
    ackExpect("R4 masked winners skipped", 8'h42);
    wr(4'd8, 8'hFF);
  endtask

  task automatic t_hold_r5_r6();
    irqIn = 8'h40;
    intAck = 1'b1;
    #1 chk("R5 valid not yet before edge", vecValid, 0);
    @(negedge clk);
    chk("R5 valid after first edge", vecValid, 1);
    chk("R6 captured vector", vecOut, 8'h46);
    irqIn = 8'h01;
    wr(4'd6, 8'h99);
    wr(4'd8, 8'h01);
    @(negedge clk);
    chk("R6 vector held while ack high", vecOut, 8'h46);
    chk("R5 valid held", vecValid, 1);
    intAck = 1'b0;
    @(negedge clk);
    chk("R5 valid drops", vecValid, 0);
    wr(4'd6, 8'h46); wr(4'd8, 8'hFF);
  endtask

  task automatic t_spurious_r7();
    irqIn = 8'h00;
    ackExpect("R7 no pending gives FF", 8'hFF);
  endtask

  task automatic t_level_r9();
    irqIn = 8'h0C; #1;
    chk("R9 two pending", irqOut, 1);
    ackExpect("R9 first service", 8'h42);
    irqIn = 8'h08; #1;
    chk("R9 still pending", irqOut, 1);
    ackExpect("R9 next source", 8'h43);
    irqIn = 8'h00; #1;
    chk("R9 cleared request drops irqOut", irqOut, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_program_r8();
    t_request_r2_r3();
    t_priority_r4();
    t_hold_r5_r6();
    t_spurious_r7();
    t_level_r9();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule